// File: doc/BRIEF.md
# Iterative AES-128 Decryption Core

This block turns one 128-bit AES-128 ciphertext block back into plaintext, one inverse round per clock. The caller does not supply the cipher key. It supplies the subkey that the encryption key schedule produces last, the round-10 subkey. The core runs the key expansion in reverse, one step per round, so each round key is derived just before it is used. No table of round keys is stored.

A transfer begins when `start_i` is high while the core is idle. On that edge the core captures the ciphertext and the decryption key and applies the initial key whitening. The core then moves through its states:
- **ST_IDLE** goes to **ST_ROUND** on an accepted start.
- **ST_ROUND** stays in ST_ROUND for the first nine iterations.
- **ST_ROUND** goes to **ST_LAST** when the ninth iteration is the one in progress.
- **ST_LAST** returns to **ST_IDLE** and fires the done pulse.

Each iteration applies the inverse row rotation, the inverse byte substitution, the previous round key and the inverse column mix. The last iteration skips the column mix. The inverse column mix is built as a small correction on each column followed by the ordinary forward column mix.

The result stays on `plain_o` until the next start is accepted. A start raised while the core is busy is dropped.

Top module: `aesd_core`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` and `busy_o` are 0 until a start is accepted.
- R2: A start is accepted only in ST_IDLE. From the edge that accepts it, `busy_o` reads 1.
- R3: Given a ciphertext and the round-10 subkey of a cipher key, `plain_o` equals the AES-128 plaintext for that cipher key.
  - Round keys are recovered in reverse with Rcon values 36, 1B, 80, 40, 20, 10, 08, 04, 02, 01.
  - The last iteration omits the inverse column mix.
- R4: Byte packing on all three data ports is column-major. The state byte in row r, column c occupies bits [8(4c+r)+7 : 8(4c+r)]. Cipher-key word c occupies bits [32c+31:32c], with its row-0 byte in the low bits.
- R5: `done_o` rises exactly 10 rising edges after the edge that accepted the start. `busy_o` is high for those 10 cycles.
- R6: `done_o` is high for exactly one cycle per completed block.
- R7: A start presented while `busy_o` is high is ignored. The running block finishes with its own result, and no extra completion follows.
- R8: Once a block completes, `plain_o` holds its value while no start is accepted, whatever the data inputs do.
- R9: A start presented in the cycle where `done_o` is high is accepted. The next block then completes with the same 10-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| cipher_i | input | 128 | Ciphertext block |
| dkey_i | input | 128 | Round-10 subkey of the encryption schedule |
| plain_o | output | 128 | Recovered plaintext, valid from `done_o` onward |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | High while iterations are in progress |

## Verification
The bench builds the core with the package defaults: a 128-bit block, 32-bit words and ten rounds. This is the only legal AES-128 setting. It makes the full reverse Rcon sequence observable through three published vector pairs that use two different cipher keys.

At this width, byte packing and row rotation errors corrupt every test vector rather than hiding in a narrow corner. The ten-cycle window is also short enough for the bench to land a start in the middle of a busy period and another start right on the done cycle.

// File: rtl/aesd_pkg.sv
package aesd_pkg;

    localparam int BLK_W    = 128;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int N_COLS   = BLK_W / WORD_W;
    localparam int N_ROWS   = WORD_W / BYTE_W;
    localparam int N_ROUNDS = 10;
    localparam int CNT_W    = $clog2(N_ROUNDS);

    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_LAST  = 2'd2
    } dec_state_e;

    // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic byte_t xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gmul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t t;
        acc = '0;
        t   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ t;
            t = xtime(t);
        end
        return acc;
    endfunction

    // a^254: product of a^2, a^4, ..., a^128 (maps 0 to 0)
    function automatic byte_t ginv(input byte_t a);
        byte_t sq;
        byte_t r;
        sq = a;
        r  = 8'h01;
        for (int i = 0; i < BYTE_W - 1; i++) begin
            sq = gmul(sq, sq);
            r  = gmul(r, sq);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(input byte_t a, input int n);
        return byte_t'((a << n) | (a >> (BYTE_W - n)));
    endfunction

    function automatic byte_t sbox(input byte_t a);
        byte_t i;
        i = ginv(a);
        return i ^ rotl8(i, 1) ^ rotl8(i, 2) ^ rotl8(i, 3) ^ rotl8(i, 4) ^ 8'h63;
    endfunction

    function automatic byte_t inv_sbox(input byte_t a);
        byte_t y;
        y = rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05;
        return ginv(y);
    endfunction

    // constant for reverse step k: x^(N_ROUNDS-1-k)
    function automatic byte_t rcon_rev(input logic [CNT_W-1:0] k);
        byte_t v;
        int    e;
        v = 8'h01;
        e = N_ROUNDS - 1 - int'(k);
        for (int i = 0; i < N_ROUNDS; i++) begin
            if (i < e) v = xtime(v);
        end
        return v;
    endfunction

endpackage

// File: rtl/aesd_key_step.sv
module aesd_key_step
    import aesd_pkg::*;
(
    input  logic [BLK_W-1:0]  key_cur_i,
    input  logic [BYTE_W-1:0] rcon_i,
    output logic [BLK_W-1:0]  key_prev_o
);

    word_t cur_w [N_COLS];
    word_t prev_top;
    word_t rot_w;
    word_t sub_w;

    for (genvar c = 0; c < N_COLS; c++) begin : g_split
        assign cur_w[c] = key_cur_i[c*WORD_W +: WORD_W];
    end

    // upper words of the earlier key fall out of neighbour XORs
    for (genvar c = 1; c < N_COLS; c++) begin : g_upper
        assign key_prev_o[c*WORD_W +: WORD_W] = cur_w[c] ^ cur_w[c-1];
    end

    assign prev_top = cur_w[N_COLS-1] ^ cur_w[N_COLS-2];

    // word rotation: row-0 byte moves to the top row
    assign rot_w = {prev_top[BYTE_W-1:0], prev_top[WORD_W-1:BYTE_W]};

    for (genvar r = 0; r < N_ROWS; r++) begin : g_sub
        assign sub_w[r*BYTE_W +: BYTE_W] = sbox(rot_w[r*BYTE_W +: BYTE_W]);
    end

    assign key_prev_o[WORD_W-1:0] = cur_w[0] ^ sub_w ^ {{(WORD_W-BYTE_W){1'b0}}, rcon_i};

endmodule

// File: rtl/aesd_inv_mix.sv
module aesd_inv_mix
    import aesd_pkg::*;
(
    input  logic [BLK_W-1:0] din_i,
    output logic [BLK_W-1:0] dout_o
);

    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        byte_t a0, a1, a2, a3;
        byte_t u, v;
        byte_t b0, b1, b2, b3;

        assign a0 = din_i[BYTE_W*(N_ROWS*c+0) +: BYTE_W];
        assign a1 = din_i[BYTE_W*(N_ROWS*c+1) +: BYTE_W];
        assign a2 = din_i[BYTE_W*(N_ROWS*c+2) +: BYTE_W];
        assign a3 = din_i[BYTE_W*(N_ROWS*c+3) +: BYTE_W];

        // correction stage: {04} times the sums of opposite bytes
        assign u  = xtime(xtime(a0 ^ a2));
        assign v  = xtime(xtime(a1 ^ a3));
        assign b0 = a0 ^ u;
        assign b1 = a1 ^ v;
        assign b2 = a2 ^ u;
        assign b3 = a3 ^ v;

        // forward column mix
        assign dout_o[BYTE_W*(N_ROWS*c+0) +: BYTE_W] = xtime(b0) ^ xtime(b1) ^ b1 ^ b2 ^ b3;
        assign dout_o[BYTE_W*(N_ROWS*c+1) +: BYTE_W] = b0 ^ xtime(b1) ^ xtime(b2) ^ b2 ^ b3;
        assign dout_o[BYTE_W*(N_ROWS*c+2) +: BYTE_W] = b0 ^ b1 ^ xtime(b2) ^ xtime(b3) ^ b3;
        assign dout_o[BYTE_W*(N_ROWS*c+3) +: BYTE_W] = xtime(b0) ^ b0 ^ b1 ^ b2 ^ xtime(b3);
    end

endmodule

// File: rtl/aesd_inv_round.sv
module aesd_inv_round
    import aesd_pkg::*;
(
    input  logic [BLK_W-1:0] state_i,
    input  logic [BLK_W-1:0] rkey_i,
    input  logic             last_i,
    output logic [BLK_W-1:0] state_o
);

    blk_t subbed;
    blk_t keyed;
    blk_t mixed;

    // row r rotates right by r columns, then bytewise inverse substitution
    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        for (genvar r = 0; r < N_ROWS; r++) begin : g_row
            localparam int SRC_C = (c - r + N_COLS) % N_COLS;
            assign subbed[BYTE_W*(N_ROWS*c+r) +: BYTE_W] =
                inv_sbox(state_i[BYTE_W*(N_ROWS*SRC_C+r) +: BYTE_W]);
        end
    end

    assign keyed = subbed ^ rkey_i;

    aesd_inv_mix u_mix (
        .din_i  (keyed),
        .dout_o (mixed)
    );

    assign state_o = last_i ? keyed : mixed;

endmodule

// File: rtl/aesd_core.sv
module aesd_core
    import aesd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] cipher_i,
    input  logic [BLK_W-1:0] dkey_i,
    output logic [BLK_W-1:0] plain_o,
    output logic             done_o,
    output logic             busy_o
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(N_ROUNDS - 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(N_ROUNDS - 2);

    dec_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    blk_t             data_q;
    blk_t             key_q;
    logic             done_q;

    blk_t             key_prev;
    blk_t             round_out;
    byte_t            rcon;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && start_i;
    assign rcon   = rcon_rev(cnt_q);

    aesd_key_step u_key (
        .key_cur_i  (key_q),
        .rcon_i     (rcon),
        .key_prev_o (key_prev)
    );

    aesd_inv_round u_round (
        .state_i (data_q),
        .rkey_i  (key_prev),
        .last_i  (state_q == ST_LAST),
        .state_o (round_out)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ROUND;
            ST_ROUND: if (cnt_q == PRE_LAST) state_d = ST_LAST;
            ST_LAST:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            data_q <= '0;
            key_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_LAST);
            if (accept) begin
                cnt_q  <= '0;
                data_q <= cipher_i ^ dkey_i;
                key_q  <= dkey_i;
            end else if (state_q != ST_IDLE) begin
                cnt_q  <= cnt_q + 1'b1;
                data_q <= round_out;
                key_q  <= key_prev;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o  = (state_q != ST_IDLE);
        done_o  = done_q;
        plain_o = data_q;
    end

    // R6
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    last_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAST) |-> (cnt_q == LAST_CNT));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && state_q == ST_ROUND) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(plain_o));

endmodule

// File: tb/aesd_core_tb.sv
module aesd_core_tb;
    import aesd_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    blk_t cipher = '0;
    blk_t dkey = '0;
    blk_t plain;
    logic done;
    logic busy;

    always #5 clk = ~clk;

    aesd_core u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .cipher_i (cipher),
        .dkey_i   (dkey),
        .plain_o  (plain),
        .done_o   (done),
        .busy_o   (busy)
    );

    localparam blk_t K_A  = 128'ha60c63b6c80c3fe18925eec9a8f914d0;
    localparam blk_t C_A1 = 128'h97ef6624f3ca9ea860367a0db47bd73a;
    localparam blk_t P_A1 = 128'h2a179373117e3de9969f402ee2bec16b;
    localparam blk_t C_A2 = 128'h320b6a19978511dcfb09dc021d842539;
    localparam blk_t P_A2 = 128'h340737e0a29831318d305a88a8f64332;
    localparam blk_t K_B  = 128'hc5302b4d8ba707f3174a94e37f1d1113;
    localparam blk_t C_B  = 128'h5ac5b47080b7cdd830047b6ad8e0c469;
    localparam blk_t P_B  = 128'hffeeddccbbaa99887766554433221100;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_done = 0;
    logic done_prev = 1'b0;
    blk_t exp_q[$];
    int   t0_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input blk_t act, input blk_t exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // monitor: pops the scoreboard on every completion
    always @(negedge clk) begin
        blk_t e;
        int   t;
        if (rst_n) begin
            if (done_prev)
                chk(done == 1'b0, "R6 single-cycle done", blk_t'(done), '0);
            if (done && !done_prev) begin
                n_done++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected completion", plain, '0);
                end else begin
                    e = exp_q.pop_front();
                    t = t0_q.pop_front();
                    chk(plain == e, "R3 R4 plaintext", plain, e);
                    chk((cyc - t) == 10, "R5 latency", blk_t'(cyc - t), blk_t'(10));
                end
            end
        end
        done_prev = done;
    end

    // driver: present a block; now=1 drives in the current negedge
    task automatic issue(input blk_t ct, input blk_t k, input blk_t pt, input bit now);
        if (!now) @(negedge clk);
        start  = 1'b1;
        cipher = ct;
        dkey   = k;
        @(negedge clk);
        start = 1'b0;
        exp_q.push_back(pt);
        t0_q.push_back(cyc);
        chk(busy == 1'b1, "R2 busy after accept", blk_t'(busy), blk_t'(1));
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", blk_t'(done), '0);
        chk(busy == 1'b0, "R1 busy in reset", blk_t'(busy), '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R1 idle after reset", blk_t'({done, busy}), '0);

        // first vector
        issue(C_A1, K_A, P_A1, 1'b0);
        wait_done();

        // R8: inputs wiggle without start, result holds
        @(negedge clk);
        cipher = C_B;
        dkey   = K_B;
        repeat (5) @(negedge clk);
        chk(plain == P_A1, "R8 hold while idle", plain, P_A1);

        // second and third vectors (R3, R4)
        issue(C_A2, K_A, P_A2, 1'b0);
        wait_done();
        issue(C_B, K_B, P_B, 1'b0);
        wait_done();

        // R7: starts during busy are dropped
        issue(C_A1, K_A, P_A1, 1'b0);
        repeat (3) @(negedge clk);
        start  = 1'b1;
        cipher = C_B;
        dkey   = K_B;
        repeat (4) @(negedge clk);
        start = 1'b0;
        snap = n_done;
        wait_done();
        repeat (14) @(negedge clk);
        chk(n_done == snap + 1, "R7 one completion only", blk_t'(n_done - snap), blk_t'(1));
        chk(busy == 1'b0, "R7 idle after ignored start", blk_t'(busy), '0);
        chk(plain == P_A1, "R7 result of running block", plain, P_A1);

        // R9: back-to-back start on the done cycle
        issue(C_A2, K_A, P_A2, 1'b0);
        wait_done();
        issue(C_B, K_B, P_B, 1'b1);
        wait_done();
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all blocks completed", blk_t'(exp_q.size()), '0);
        chk(plain == P_B, "R9 back-to-back result", plain, P_B);

        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule